// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is a 32-bit down-counter that hands timed interrupt requests to an interrupt controller. A free-running prescaler divides the bus clock by a power of two chosen through a small divide register, and every prescaled tick steps the counter down by one. When the counter has sat at zero for one tick it expires. If the timer's vector entry is unmasked, the block then drives a one-cycle, edge-type request that carries the entry's 8-bit vector.

Software programs the block through a write strobe, a read strobe, a 2-bit register select and a 32-bit data bus. The four registers are the reload value (select 0), the live count (select 1, read only), the divide code (select 2) and the vector entry (select 3). Writing the reload value starts a new run at once. The entry picks one-shot or periodic operation. Deciding which request wins at the controller is not done here.

Top module: `divided_countdown_timer`

## Requirements
- R1: After reset every register reads 0 and no request is driven.
- R2: A divide-register write keeps only data bits 3, 1 and 0. The register reads back as wdata & 0xB.
- R3: The divide code is {bit3, bit1, bit0}. Prescaled ticks come every 2^((code+1) mod 8) clocks, so code 7 gives a tick on every clock and code 0 a tick every 2 clocks.
- R4: In the vector entry, bits [7:0] hold the vector, bit 16 is the mask and bit 17 selects periodic mode. All other bits read as 0.
- R5: Writing a value V to the reload register loads V into the live count and clears the prescaler. The first decrement lands 2^shift clocks after the write, and a rewrite during a run starts timing over.
- R6: In one-shot mode the count steps down to 0 and one expiry occurs V+1 ticks after the load. The count then stays at 0 and no further expiry occurs.
- R7: In periodic mode the expiry tick reloads the count with V, so expiries repeat every V+1 ticks.
- R8: An expiry with the mask clear drives irq_valid high for exactly one clock, with irq_vector equal to the entry's vector, in the clock after the expiring tick's edge. A masked expiry drives nothing, but the count keeps running.
- R9: While the reload value is 0 the timer is idle and never drives a request.
- R10: Writes to the live-count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 reload, 1 live count, 2 divide, 3 vector entry |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational while rd_en is high, 0 otherwise |
| irq_valid | output | 1 | One-clock expiry request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The bench sweeps divide codes, including the code 7 wrap to divide-by-1 and the largest divide of 128. A design that shifted by the raw code, or that read bit 2 instead of bit 3, would expire at the wrong cycle. Each case measures the exact latency to the first expiry (V+1 ticks) and, in periodic mode, the gap to the second. An off-by-one period or a failed reload shows up as a wrong cycle count or a missing request. In one-shot mode the bench confirms the count stays at 0 and that no second request follows; a counter that wrapped would fail here. Directed cases cover a masked run that still counts down, a mid-run rewrite that must restart the prescaler, a zero reload that must stay silent, and ignored writes to the live count.

// File: rtl/divided_countdown_timer.sv
module divided_countdown_timer #(
  parameter int CW    = 32,
  parameter int VW    = 8,
  parameter int PRE_W = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq_valid,
  output logic [VW-1:0] irq_vector
);
  localparam logic [1:0] SEL_INIT = 2'd0;
  localparam logic [1:0] SEL_CUR  = 2'd1;
  localparam logic [1:0] SEL_DIV  = 2'd2;
  localparam logic [1:0] SEL_ENT  = 2'd3;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  logic [CW-1:0]    init_q, cur_q;
  logic [3:0]       div_q;
  logic [VW-1:0]    vec_q;
  logic             mask_q, per_q, armed_q;
  logic [PRE_W-1:0] pre_q;

  wire [2:0]       code   = {div_q[3], div_q[1:0]};
  wire [2:0]       shift  = code + 3'd1;
  wire [PRE_W-1:0] pmask  = (PRE_W'(1) << shift) - PRE_W'(1);
  wire             tick   = (pre_q & pmask) == pmask;
  wire             wr_init = wr_en && addr == SEL_INIT;
  wire             at_zero = cur_q == '0;
  wire             expire  = tick && armed_q && at_zero && !wr_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      div_q  <= '0;
      vec_q  <= '0;
      mask_q <= 1'b0;
      per_q  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        SEL_INIT: init_q <= wdata[CW-1:0];
        SEL_DIV:  div_q  <= wdata[3:0] & 4'hB;
        SEL_ENT: begin
          vec_q  <= wdata[VW-1:0];
          mask_q <= wdata[MASK_BIT];
          per_q  <= wdata[PER_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= wr_init ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else if (wr_init) begin
      cur_q   <= wdata[CW-1:0];
      armed_q <= wdata[CW-1:0] != '0;
    end else if (tick && armed_q) begin
      if (!at_zero)   cur_q   <= cur_q - CW'(1);
      else if (per_q) cur_q   <= init_q;
      else            armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= expire && !mask_q;
      irq_vector <= vec_q;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        SEL_INIT: rdata[CW-1:0] = init_q;
        SEL_CUR:  rdata[CW-1:0] = cur_q;
        SEL_DIV:  rdata[3:0]    = div_q;
        default: begin
          rdata[VW-1:0]   = vec_q;
          rdata[MASK_BIT] = mask_q;
          rdata[PER_BIT]  = per_q;
        end
      endcase
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);
  a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask_q));
  a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_q) == '0 |-> !irq_valid);
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SEL_INIT) |=> cur_q == $past(wdata[CW-1:0]));
  a_r6_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_q && at_zero && !(wr_en && addr == SEL_INIT)) |=> cur_q == '0);
  a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && per_q) |=> cur_q == $past(init_q));
endmodule

// File: tb/divided_countdown_timer_tb.sv
module divided_countdown_timer_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_chk = 0, n_bad = 0, cyc = 0;

  divided_countdown_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // div write data, reload V, periodic, vector, expected clocks to expiry
  typedef struct packed {
    logic [31:0] dv; logic [31:0] v; logic per; logic [7:0] vec; int unsigned exp;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{32'h0000000B, 32'd3, 1'b0, 8'h41, 4},
    '{32'h00000000, 32'd2, 1'b1, 8'h22, 6},
    '{32'h00000001, 32'd1, 1'b0, 8'h13, 8},
    '{32'h00000008, 32'd1, 1'b1, 8'h84, 64},
    '{32'h00000003, 32'd2, 1'b0, 8'h35, 48},
    '{32'h0000000A, 32'd1, 1'b0, 8'hA6, 256},
    '{32'h000000F4, 32'd4, 1'b1, 8'h77, 10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a; #1; d = rdata; rd_en = 1'b0;
  endtask

  // count clocks after the current negedge until irq_valid, up to lim; 0 = none
  task automatic wait_irq(input int lim, output int k, output logic [7:0] v);
    k = 0; v = '0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (irq_valid) begin k = i; v = irq_vector; break; end
    end
  endtask

  initial begin
    wait (cyc > 100000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected below 100000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  vv;
    int k;
    repeat (3) @(negedge clk);
    check("R1 irq", {31'b0, irq_valid}, 0);
    for (int a = 0; a < 4; a++) begin rd(2'(a), r); check("R1 reg", r, 0); end
    rst_n = 1'b1;
    @(negedge clk);

    wr(2'd2, 32'hFFFFFFFF); rd(2'd2, r); check("R2 div mask", r, 32'hB);
    wr(2'd3, 32'hFFFFFFFF); rd(2'd3, r); check("R4 entry fields", r, 32'h000300FF);
    wr(2'd1, 32'h55); rd(2'd1, r); check("R10 cur read only", r, 0);

    // R9: zero reload, unmasked, stays silent
    wr(2'd2, 32'hB); wr(2'd3, 32'h0); wr(2'd0, 32'd0);
    wait_irq(60, k, vv); check("R9 idle", k, 0);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 32'd0);
      wr(2'd2, TBL[i].dv);
      wr(2'd3, {14'b0, TBL[i].per, 1'b0, 8'b0, TBL[i].vec});
      wr(2'd0, TBL[i].v);
      wait_irq(600, k, vv);
      check("R3 R6 first expiry clocks", k, TBL[i].exp);
      check("R8 vector", vv, TBL[i].vec);
      if (TBL[i].per) begin
        wait_irq(600, k, vv);
        check("R7 period clocks", k, TBL[i].exp);
      end else begin
        wait_irq(2 * TBL[i].exp, k, vv);
        check("R6 no second expiry", k, 0);
        rd(2'd1, r); check("R6 count holds zero", r, 0);
      end
    end

    // R5: mid-run rewrite restarts timing
    wr(2'd0, 32'd0); wr(2'd2, 32'hB); wr(2'd3, 32'h09);
    wr(2'd0, 32'd5);
    repeat (3) @(negedge clk);
    rd(2'd1, r); check("R5 live count", r, 2);
    wr(2'd0, 32'd5);
    wait_irq(20, k, vv); check("R5 restart latency", k, 6);

    // R8: masked one-shot still counts, no request
    wr(2'd0, 32'd0); wr(2'd3, 32'h0001_0010);
    wr(2'd0, 32'd2);
    wait_irq(12, k, vv); check("R8 masked silent", k, 0);
    rd(2'd1, r); check("R8 masked counted", r, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule